// File: doc/BRIEF.md
# Internal clock source selector-divider

This block produces up to six divided clock-enable strobes for on-chip consumers. Every consumer owns a five-bit slice of one 32-bit control word. Within that slice, the upper three bits pick the input. The input is either nothing (the consumer is off), an auxiliary PLL strobe, or one of six frequency-generator strobes. The lower two bits pick a small divide ratio from a fixed table. The block counts ticks of the selected input and emits one output pulse for every N of them.

Each input is a single-cycle enable strobe in the block's clock domain. The output strobes use the same convention. A configuration change does not take effect mid-period. It is taken up only when the running period completes, or at once if the consumer is off. Because of this, no consumer ever sees a shortened period. A parameter selects the legacy divide table or the extended one, which turns code 2 into a divide-by-3.

Top module: `intclk_selector`

## Requirements
- R1: Reset clears the control word to zero, which turns every consumer off. A write (`cfg_we` high) stores `cfg_wdata`, and `cfg_rdata` shows it from the following cycle. Without a write, the word holds.
- R2: Consumer i (0 to 5) is configured only by control bits [5i+4:5i]. Source code sits in bits [5i+4:5i+2] and divide code in [5i+1:5i]. A change in another consumer's slice does not alter its output.
- R3: Source code 0 means the consumer is off. Its output stays low and its divide count is held at zero.
- R4: Source code 1 selects `src_tick[0]` (auxiliary PLL). Codes 2 to 7 select `src_tick[1]` to `src_tick[6]` (frequency generators 0 to 5).
- R5: With the legacy table (EXT_DIV = 0), divide codes 0, 1, 2 and 3 give ratios 1, 4, 1 and 2. The output pulses once on every N-th tick of the selected input.
- R6: With the extended table (EXT_DIV = 1), divide code 2 gives ratio 3. Codes 0, 1 and 3 keep ratios 1, 4 and 2.
- R7: A new source or divide code is taken up only in the cycle in which the current period's last selected tick arrives, or in any cycle while the consumer is off. The count then restarts at zero.
- R8: An output pulse is exactly one cycle wide. It appears in the cycle after the selected tick that completes the period.
- R9: Ticks on inputs that are not selected have no effect on a consumer's count or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Current control word |
| src_tick | input | 7 | Source strobes: bit 0 auxiliary PLL, bits 1 to 6 frequency generators 0 to 5 |
| out_tick | output | 6 | Divided strobe per consumer |

## Verification
A wrong active source or ratio shows on the consumer's output at the next selected tick. The pulse either lands on the wrong tick or comes from the wrong input, and it is visible one cycle later. A divide counter that is off by one shifts every following pulse. The error therefore persists until the consumer is turned off, and it is caught within at most four selected ticks. A configuration taken up mid-period gives one shortened or lengthened period right after a write, which is why the bench rewrites the word at random points inside running periods.

// File: rtl/intclk_pkg.sv
package intclk_pkg;

  localparam int FIELD_W   = 5;
  localparam int SRC_W     = 3;
  localparam int DIV_W     = 2;
  localparam int MAX_RATIO = 4;
  localparam int CNT_W     = $clog2(MAX_RATIO);

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
  } lane_cfg_t;

  // Ratio for a divide code; the extended table turns code 2 into 3.
  function automatic logic [CNT_W:0] ratio_of(input logic [DIV_W-1:0] code,
                                              input bit ext);
    logic [CNT_W:0] r;
    case (code)
      2'd0:    r = (CNT_W+1)'(1);
      2'd1:    r = (CNT_W+1)'(4);
      2'd2:    r = ext ? (CNT_W+1)'(3) : (CNT_W+1)'(1);
      default: r = (CNT_W+1)'(2);
    endcase
    return r;
  endfunction

  // Count value reached on the tick that closes a period.
  function automatic logic [CNT_W-1:0] final_count(input logic [DIV_W-1:0] code,
                                                   input bit ext);
    logic [CNT_W:0] r;
    r = ratio_of(code, ext) - 1'b1;
    return r[CNT_W-1:0];
  endfunction

endpackage

// File: rtl/intclk_ctrl_reg.sv
module intclk_ctrl_reg #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/intclk_lane.sv
module intclk_lane
  import intclk_pkg::*;
#(
  parameter int SRC_N   = 7,
  parameter bit EXT_DIV = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SRC_N-1:0]    src_tick,
  input  logic [FIELD_W-1:0]  field,
  output logic                tick_o,
  output logic                load_o,
  output logic                en_o,
  output logic [FIELD_W-1:0]  cfg_o
);

  lane_cfg_t        act;
  logic [CNT_W-1:0] cnt;
  logic             sel_tick;
  logic             period_end;

  // Source mux: code k selects strobe k-1, code 0 selects nothing.
  always_comb begin
    sel_tick = 1'b0;
    for (int k = 0; k < SRC_N; k++) begin
      if (act.src == SRC_W'(k + 1)) sel_tick = src_tick[k];
    end
  end

  assign en_o       = (act.src != '0);
  assign period_end = sel_tick && (cnt == final_count(act.div, EXT_DIV));
  assign load_o     = !en_o || period_end;
  assign cfg_o      = act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act    <= '0;
      cnt    <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= en_o && period_end;
      if (load_o) begin
        act <= lane_cfg_t'(field);
        cnt <= '0;
      end else if (sel_tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/intclk_selector.sv
module intclk_selector
  import intclk_pkg::*;
#(
  parameter int LANES   = 6,
  parameter int REG_W   = 32,
  parameter bit EXT_DIV = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic [LANES:0]   src_tick,
  output logic [LANES-1:0] out_tick
);

  localparam int SRC_N  = LANES + 1;
  localparam int USED_W = LANES * FIELD_W;

  logic [LANES-1:0]  lane_en;
  logic [LANES-1:0]  lane_load;
  logic [USED_W-1:0] lane_cfg;

  intclk_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (cfg_rdata)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    intclk_lane #(.SRC_N(SRC_N), .EXT_DIV(EXT_DIV)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .field    (cfg_rdata[i*FIELD_W +: FIELD_W]),
      .tick_o   (out_tick[i]),
      .load_o   (lane_load[i]),
      .en_o     (lane_en[i]),
      .cfg_o    (lane_cfg[i*FIELD_W +: FIELD_W])
    );
  end

endmodule

// File: rtl/intclk_selector_sva.sv
module intclk_selector_sva #(
  parameter int LANES = 6,
  parameter int REG_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [REG_W-1:0]   cfg_wdata,
  input logic [REG_W-1:0]   cfg_rdata,
  input logic [LANES-1:0]   out_tick,
  input logic [LANES-1:0]   lane_en,
  input logic [LANES-1:0]   lane_load,
  input logic [LANES*5-1:0] lane_cfg
);

  assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_quiet_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_en[i] |=> !out_tick[i]);

    assert_cfg_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_load[i] |=> $stable(lane_cfg[i*5 +: 5]));

    assert_slice_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lane_load[i] |=> lane_cfg[i*5 +: 5] == $past(cfg_rdata[i*5 +: 5]));

    assert_pulse_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick[i] |-> $past(lane_load[i]));
  end

endmodule

bind intclk_selector intclk_selector_sva #(.LANES(LANES), .REG_W(REG_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .out_tick  (out_tick),
  .lane_en   (lane_en),
  .lane_load (lane_load),
  .lane_cfg  (lane_cfg)
);

// File: tb/intclk_selector_bench.sv
module intclk_selector_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [6:0]  src_tick = '0;
  wire  [31:0] rd_l, rd_x;
  wire  [5:0]  out_l, out_x;

  always #4 clk = ~clk;

  intclk_selector #(.EXT_DIV(1'b0)) u_intclk_selector (
    .clk(clk), .rst_n(rst_n), .cfg_we(wr_en), .cfg_wdata(wr_data),
    .cfg_rdata(rd_l), .src_tick(src_tick), .out_tick(out_l));

  intclk_selector #(.EXT_DIV(1'b1)) u_intclk_selector_ext (
    .clk(clk), .rst_n(rst_n), .cfg_we(wr_en), .cfg_wdata(wr_data),
    .cfg_rdata(rd_x), .src_tick(src_tick), .out_tick(out_x));

  int    checks = 0;
  int    errors = 0;
  bit    running = 1'b0;
  bit    done = 1'b0;
  string phase = "R1";

  // Reference state: [variant][consumer]
  int          m_src [2][6];
  int          m_div [2][6];
  int          m_cnt [2][6];
  logic [5:0]  m_out [2];
  logic [31:0] m_reg;
  int          ratio_tbl [2][4] = '{'{1, 4, 1, 2}, '{1, 4, 3, 2}};

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int  r;
    bit  tk;
    bit  fin;
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin
        m_out[v] = '0;
        for (int i = 0; i < 6; i++) begin
          m_src[v][i] = 0; m_div[v][i] = 0; m_cnt[v][i] = 0;
        end
      end
      m_reg = '0;
    end else begin
      for (int v = 0; v < 2; v++) begin
        for (int i = 0; i < 6; i++) begin
          r   = ratio_tbl[v][m_div[v][i]];
          tk  = (m_src[v][i] != 0) && src_tick[m_src[v][i] - 1];
          fin = tk && (m_cnt[v][i] == r - 1);
          m_out[v][i] = fin;
          if (m_src[v][i] == 0 || fin) begin
            m_src[v][i] = int'((m_reg >> (5*i + 2)) & 32'd7);
            m_div[v][i] = int'((m_reg >> (5*i)) & 32'd3);
            m_cnt[v][i] = 0;
          end else if (tk) begin
            m_cnt[v][i]++;
          end
        end
      end
      if (wr_en) m_reg = wr_data;
    end
  end

  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R1", "readback legacy", rd_l, m_reg);
      chk("R1", "readback extended", rd_x, m_reg);
      chk(phase, "out legacy", {26'd0, out_l}, {26'd0, m_out[0]});
      chk(phase, "out extended", {26'd0, out_x}, {26'd0, m_out[1]});
    end
  end

  task automatic step(bit we, logic [31:0] d, logic [6:0] t);
    @(negedge clk);
    #1;
    wr_en = we;
    wr_data = d;
    src_tick = t;
  endtask

  function automatic logic [31:0] all_lanes(int src, int div);
    logic [31:0] w = '0;
    for (int i = 0; i < 6; i++) w |= 32'((src << 2) | div) << (5*i);
    return w;
  endfunction

  initial begin
    repeat (3) step(1'b0, '0, '0);
    rst_n = 1'b1;
    step(1'b0, '0, '0);
    chk("R1", "reset word legacy", rd_l, 32'd0);
    chk("R1", "reset word extended", rd_x, 32'd0);
    chk("R1", "reset outputs", {20'd0, out_l, out_x}, 32'd0);
    running = 1'b1;

    // Single consumer enabled at a time
    phase = "R2";
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 32'd7 << (5*i), 7'($urandom));
      repeat (30) step(1'b0, '0, 7'($urandom));
    end

    // Each source code on every consumer
    phase = "R4";
    for (int s = 1; s < 8; s++) begin
      step(1'b1, all_lanes(s, 0), 7'($urandom));
      repeat (30) step(1'b0, '0, 7'($urandom));
    end

    // Each divide code, consumer i on generator i
    for (int d = 0; d < 4; d++) begin
      logic [31:0] w = '0;
      phase = (d == 2) ? "R6" : "R5";
      for (int i = 0; i < 6; i++) w |= 32'(((i + 2) << 2) | d) << (5*i);
      step(1'b1, w, 7'($urandom));
      repeat (60) step(1'b0, '0, 7'($urandom));
    end

    // Isolated ticks, pulse width and latency
    phase = "R8";
    step(1'b1, all_lanes(1, 0), '0);
    for (int k = 0; k < 10; k++) begin
      step(1'b0, '0, 7'h01);
      repeat (3) step(1'b0, '0, '0);
    end

    // Rewrites at arbitrary points inside running periods
    phase = "R7";
    for (int k = 0; k < 400; k++)
      step((k % 3) == 0, $urandom, 7'($urandom));

    // Consumers turned off while others run
    phase = "R3";
    for (int k = 0; k < 100; k++) begin
      logic [31:0] w = $urandom;
      for (int i = 0; i < 6; i += 2) w &= ~(32'd28 << (5*i));
      step((k % 10) == 0, w, 7'($urandom));
    end

    // Only unselected inputs toggle
    phase = "R9";
    step(1'b1, all_lanes(1, 0), '0);
    repeat (60) step(1'b0, '0, {6'($urandom), 1'b0});
    step(1'b0, '0, '0);
    chk("R9", "no pulse from unselected inputs", {20'd0, out_l, out_x}, 32'd0);

    step(1'b0, '0, '0);
    running = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule